// File: doc/BRIEF.md
# Addressed Three-Bank Serial Display Loader

This block sits between a host microcontroller and the segment drivers of a three-digit multiplexed vacuum fluorescent display. The host writes over a three-wire synchronous link made of an enable line, a serial clock and a data line. Each transfer has two parts. The host first shifts an 8-bit device address with enable low. It then raises enable and shifts a 104-bit payload. The payload holds 88 segment bits, a 14-bit control field and, at the end, a 2-bit code that selects which of three display banks the transfer writes.

The link inputs are resynchronised into the system clock domain and edge-detected. Bits are taken on rising serial clock edges. The payload builds up in a shift register. When enable falls, the payload is copied into the bank it names, but only if the address matched and exactly 104 payload bits arrived. A transfer to the first bank also refreshes the 10-bit dimmer value. Three transfers refresh the whole 264-segment image. Loading works at any time, including while the display is blanked downstream.

Top module: `vfd_serial_loader`

## Requirements
- R1: After reset, all three banks and the dimmer value read zero.
- R2: The address is the last 8 bits clocked while enable is low, least significant bit first, and must equal 84 hex (sent as 0,0,1,0,0,0,0,1). A transfer with any other address changes no output.
- R3: Payload bit 1, the first sent after enable rises, lands in bank bit 0. Payload bit n lands in bank bit n-1, up to bit 88 in bank bit 87.
- R4: Payload bits 103 and 104 form the bank code, and bit 103 is the code's LSB. Code 0 writes bank 1, code 1 writes bank 2 and code 2 writes bank 3. Code 3 writes nothing.
- R5: Payload bits 89 to 98 are the dimmer value, LSB first. They are taken only when the code is 0. With codes 1 and 2 the dimmer is unchanged.
- R6: A transfer is committed only when exactly 104 payload bits were received. Shorter or longer transfers are discarded.
- R7: Outputs change only in response to a falling enable. The update appears in the fixed system cycle that follows two-stage synchronisation of that edge, and outputs hold their values during a transfer.
- R8: The serial clock may idle high or low between transfers with the same result.
- R9: Serial clock edges while enable is low never add payload bits, and edges while enable is high never change the held address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial enable from host |
| ser_clk | input | 1 | Serial bit clock from host |
| ser_dat | input | 1 | Serial data from host |
| bank1_seg | output | 88 | Segment image for digit 1 |
| bank2_seg | output | 88 | Segment image for digit 2 |
| bank3_seg | output | 88 | Segment image for digit 3 |
| dimmer | output | 10 | Digit duty value |

## Verification
The bench sends frames one bit short and one bit long. A loader with an off-by-one length rule would commit one of them and damage a bank. It sends the unused bank code and a near-miss address 85 hex, which a weak decoder would let through and so overwrite a bank or the dimmer. Extra bits are sent ahead of the address to show that only the last eight count, and frames are also sent with the clock idling high. A loader that counted the idle level as an edge would shift in an extra bit and lose the frame. Outputs are sampled just before enable falls, to catch a design that updates during the transfer, and a cycle-level model is compared on every clock.

// File: rtl/vfdl_pkg.sv
package vfdl_pkg;
  localparam int ADDR_W  = 8;
  localparam int DISP_W  = 88;
  localparam int CTRL_W  = 14;
  localparam int DIM_W   = 10;
  localparam int DIR_W   = 2;
  localparam int NBANK   = 3;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 8'h84;

  typedef enum logic [DIR_W-1:0] {
    DIR_BANK1 = 2'd0,
    DIR_BANK2 = 2'd1,
    DIR_BANK3 = 2'd2,
    DIR_NONE  = 2'd3
  } dir_t;
endpackage

// File: rtl/vfdl_sync.sv
module vfdl_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync_cur,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      sync_cur  <= '0;
      sync_prev <= '0;
    end else begin
      meta_q    <= raw;
      sync_cur  <= meta_q;
      sync_prev <= sync_cur;
    end
  end
endmodule

// File: rtl/vfdl_rx.sv
module vfdl_rx #(
  parameter int ADDR_W = 8,
  parameter int PAY_W  = 104,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h84
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_cur,
  input  logic             en_prev,
  input  logic             sck_cur,
  input  logic             sck_prev,
  input  logic             dat_cur,
  output logic             commit,
  output logic [PAY_W-1:0] frame
);
  localparam int CNT_W = $clog2(PAY_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(PAY_W + 1);

  logic              sck_rise, en_rise, en_fall;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              match_q, match_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAY_W-1:0]  sr_q, sr_d;

  assign sck_rise = sck_cur & ~sck_prev;
  assign en_rise  = en_cur & ~en_prev;
  assign en_fall  = ~en_cur & en_prev;

  always_comb begin
    addr_d  = addr_q;
    match_d = match_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    if (!en_cur && sck_rise) begin
      addr_d = {dat_cur, addr_q[ADDR_W-1:1]};
    end
    if (en_rise) begin
      match_d = (addr_q == DEV_ADDR);
      cnt_d   = '0;
    end else if (en_cur && match_q && sck_rise) begin
      sr_d = {dat_cur, sr_q[PAY_W-1:1]};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
    if (en_fall) begin
      match_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      match_q <= 1'b0;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else begin
      addr_q  <= addr_d;
      match_q <= match_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
    end
  end

  assign commit = en_fall && match_q && (cnt_q == CNT_FULL);
  assign frame  = sr_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cur |=> $stable(cnt_q)); // R9
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en_cur |=> $stable(addr_q)); // R9
endmodule

// File: rtl/vfdl_banks.sv
module vfdl_banks
  import vfdl_pkg::*;
#(
  parameter int DISP_W = 88,
  parameter int CTRL_W = 14,
  parameter int DIM_W  = 10,
  parameter int NB     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [DISP_W+CTRL_W+DIR_W-1:0] frame,
  output logic [NB-1:0][DISP_W-1:0]  bank,
  output logic [DIM_W-1:0]           dim
);
  localparam int PAY_W = DISP_W + CTRL_W + DIR_W;

  dir_t             dir;
  logic [NB-1:0]    wr_en;
  logic             dim_en;
  logic [DIM_W-1:0] dim_d;
  logic             unused_ctrl;

  assign dir         = dir_t'(frame[PAY_W-1 -: DIR_W]);
  assign unused_ctrl = ^frame[PAY_W-DIR_W-1 : DISP_W+DIM_W];
  assign dim_en      = commit && (dir == DIR_BANK1);
  assign dim_d       = dim_en ? frame[DISP_W +: DIM_W] : dim;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [DISP_W-1:0] bank_d;
      assign wr_en[b] = commit && (dir == dir_t'(b));
      assign bank_d   = wr_en[b] ? frame[DISP_W-1:0] : bank[b];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank[b] <= '0;
        else        bank[b] <= bank_d;
      end

      AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(bank[b])); // R7
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dim <= '0;
    else        dim <= dim_d;
  end

  AST_DIM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && frame[PAY_W-1 -: DIR_W] == 2'd0) |=> $stable(dim)); // R5
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R4
endmodule

// File: rtl/vfd_serial_loader.sv
module vfd_serial_loader
  import vfdl_pkg::*;
#(
  parameter int DISP_W = vfdl_pkg::DISP_W,
  parameter int CTRL_W = vfdl_pkg::CTRL_W,
  parameter int DIM_W  = vfdl_pkg::DIM_W,
  parameter int ADDR_W = vfdl_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] DEV_ADDR = vfdl_pkg::DEV_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DISP_W-1:0] bank1_seg,
  output logic [DISP_W-1:0] bank2_seg,
  output logic [DISP_W-1:0] bank3_seg,
  output logic [DIM_W-1:0]  dimmer
);
  localparam int PAY_W = DISP_W + CTRL_W + DIR_W;

  logic                         rst_q1, rst_q2;
  logic [2:0]                   s_cur, s_prev;
  logic                         commit;
  logic [PAY_W-1:0]             frame;
  logic [NBANK-1:0][DISP_W-1:0] bank;
  logic                         unused_dat_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  vfdl_sync #(.W(3)) i_sync (
    .clk(clk), .rst_n(rst_q2),
    .raw({ser_en, ser_clk, ser_dat}),
    .sync_cur(s_cur), .sync_prev(s_prev)
  );

  assign unused_dat_prev = s_prev[0];

  vfdl_rx #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .DEV_ADDR(DEV_ADDR)) i_rx (
    .clk(clk), .rst_n(rst_q2),
    .en_cur(s_cur[2]), .en_prev(s_prev[2]),
    .sck_cur(s_cur[1]), .sck_prev(s_prev[1]),
    .dat_cur(s_cur[0]),
    .commit(commit), .frame(frame)
  );

  vfdl_banks #(.DISP_W(DISP_W), .CTRL_W(CTRL_W), .DIM_W(DIM_W), .NB(NBANK)) i_banks (
    .clk(clk), .rst_n(rst_q2),
    .commit(commit), .frame(frame),
    .bank(bank), .dim(dimmer)
  );

  assign bank1_seg = bank[0];
  assign bank2_seg = bank[1];
  assign bank3_seg = bank[2];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q2 |=> (dimmer == '0 && bank1_seg == '0)); // R1
endmodule

// File: tb/test_vfd_serial_loader.sv
module test_vfd_serial_loader;
  logic clk = 1'b0;
  logic rst_n, ser_en, ser_clk, ser_dat;
  logic [87:0] bank1_seg, bank2_seg, bank3_seg;
  logic [9:0]  dimmer;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  vfd_serial_loader i_vfd_serial_loader (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .bank1_seg(bank1_seg), .bank2_seg(bank2_seg),
    .bank3_seg(bank3_seg), .dimmer(dimmer)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_r1, m_r2;
  logic [2:0]  ms1, ms2, mp;
  bit          maq[$];
  bit          mpq[$];
  bit          m_match;
  logic [87:0] m_bank [3];
  logic [9:0]  m_dim;

  task automatic model_clear();
    ms1 = 0; ms2 = 0; mp = 0; m_match = 0;
    maq.delete(); mpq.delete();
    for (int i = 0; i < 8; i++) maq.push_back(1'b0);
    for (int b = 0; b < 3; b++) m_bank[b] = '0;
    m_dim = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      model_clear();
    end else begin
      if (!m_r2) model_clear();
      else begin
        bit ce, cep, ckr, d;
        ce = ms2[2]; cep = mp[2]; ckr = ms2[1] & ~mp[1]; d = ms2[0];
        if (!ce && ckr) begin
          maq.push_back(d);
          if (maq.size() > 8) void'(maq.pop_front());
        end
        if (ce && !cep) begin
          logic [7:0] v;
          for (int i = 0; i < 8; i++) v[i] = maq[i];
          m_match = (v == 8'h84);
          mpq.delete();
        end else if (ce && m_match && ckr) mpq.push_back(d);
        if (!ce && cep) begin
          if (m_match && mpq.size() == 104) begin
            int code;
            code = mpq[102] + 2 * mpq[103];
            if (code < 3)
              for (int i = 0; i < 88; i++) m_bank[code][i] = mpq[i];
            if (code == 0)
              for (int i = 0; i < 10; i++) m_dim[i] = mpq[88 + i];
          end
          m_match = 0;
        end
        mp = ms2; ms2 = ms1; ms1 = {ser_en, ser_clk, ser_dat};
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R7 model bank1", bank1_seg, m_bank[0]);
      chk("R7 model bank2", bank2_seg, m_bank[1]);
      chk("R7 model bank3", bank3_seg, m_bank[2]);
      chk("R7 model dimmer", dimmer, m_dim);
    end
  end

  logic [87:0] eb [3];
  logic [9:0]  edim;

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [127:0] mk(logic [87:0] disp, logic [13:0] ctrl, logic [1:0] code);
    logic [127:0] p;
    p = '0;
    p[87:0]   = disp;
    p[101:88] = ctrl;
    p[102]    = code[0];
    p[103]    = code[1];
    return p;
  endfunction

  task automatic send(logic [15:0] a, int alen, logic [127:0] p, int n, bit hi);
    ser_en = 0; ser_clk = hi; waitc(10);
    for (int i = 0; i < alen; i++) begin
      ser_clk = 0; ser_dat = a[i]; waitc(10);
      ser_clk = 1; waitc(10);
    end
    if (!hi) ser_clk = 0;
    waitc(10);
    ser_en = 1; waitc(10);
    for (int i = 0; i < n; i++) begin
      ser_clk = 0; ser_dat = p[i]; waitc(10);
      ser_clk = 1; waitc(10);
    end
    if (!hi) ser_clk = 0;
    waitc(10);
    chk("R7 hold bank1 before enable falls", bank1_seg, eb[0]);
    chk("R7 hold dimmer before enable falls", dimmer, edim);
    ser_en = 0; waitc(12);
  endtask

  task automatic check_all(string tag);
    chk({tag, " bank1"}, bank1_seg, eb[0]);
    chk({tag, " bank2"}, bank2_seg, eb[1]);
    chk({tag, " bank3"}, bank3_seg, eb[2]);
    chk({tag, " dimmer"}, dimmer, edim);
  endtask

  localparam logic [87:0] PA = 88'h8000000000000000000001;
  localparam logic [87:0] PB = 88'hDEADBEEFCAFEF00D123456;
  localparam logic [87:0] PC = 88'h0F0F0F0F0F0F0F0F0F0F0F;
  localparam logic [87:0] PD = 88'h123456789ABCDEF0123456;

  initial begin
    rst_n = 0; ser_en = 0; ser_clk = 0; ser_dat = 0;
    for (int b = 0; b < 3; b++) eb[b] = '0;
    edim = '0;
    waitc(5);
    rst_n = 1;
    waitc(5);
    cmp_en = 1;
    check_all("R1 reset");

    send(16'h0084, 8, mk(PA, {4'b1010, 10'h1FF}, 2'd0), 104, 0);
    eb[0] = PA; edim = 10'h1FF;
    check_all("R3 R5 bank1 with dimmer");

    send(16'h0084, 8, mk(PB, {4'b0101, 10'h2AA}, 2'd1), 104, 0);
    eb[1] = PB;
    check_all("R4 R5 bank2 dimmer kept");

    send(16'h0084, 8, mk(PC, 14'h3FFF, 2'd2), 104, 1);
    eb[2] = PC;
    check_all("R4 R8 bank3 idle-high clock");

    send(16'h0084, 8, mk(PD, 14'h0123, 2'd3), 104, 0);
    check_all("R4 code 3 ignored");

    send(16'h0085, 8, mk(PD, 14'h0123, 2'd0), 104, 0);
    check_all("R2 wrong address");

    send(16'h0084, 8, mk(PD, 14'h0123, 2'd0), 103, 0);
    check_all("R6 short frame");

    send(16'h0084, 8, mk(PD, 14'h0123, 2'd0), 105, 1);
    check_all("R6 long frame");

    send(16'h84FF, 16, mk(PD, {4'b0000, 10'h3FE}, 2'd0), 104, 1);
    eb[0] = PD; edim = 10'h3FE;
    check_all("R9 R2 last eight address bits");

    send(16'h0084, 8, mk(PD, 14'h0000, 2'd1), 104, 1);
    eb[1] = PD;
    check_all("R8 bank2 idle-high clock");

    waitc(5);
    cmp_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule